// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel bytes. A built-in rate generator divides the system clock into a tick that runs at sixteen times the bit rate. The receiver takes three samples in the middle of every bit and decides the bit by a two-out-of-three vote, so a single short spike cannot flip a bit. It first qualifies the start bit, then collects eight data bits least significant bit first, an optional wakeup bit and an optional parity bit, and finally checks the stop bit.

Each frame produces a one-cycle result strobe carrying the byte, the wakeup bit, a parity error flag and a framing error flag. A byte that arrives with an error is still delivered, with its flags set, so a downstream buffer can store it next to its status. Configuration inputs are expected to stay stable while a frame is in flight.

Top module: `mv_uart_rx`

## Requirements
- R1: The sampling tick occurs once every P*(n+1) clock cycles, where n is `cfg_div` (0 to 255) and P is 2 when `cfg_slow` is 0 and 32 when it is 1. One bit lasts 16 ticks.
- R2: `rx_in` passes through two flip-flops before use. Each bit is decided by a 2-of-3 majority over the samples taken at ticks 7, 8 and 9 of that bit, so a disturbance caught by only one sample does not change the bit.
- R3: A low level seen in idle marks tick 0 of a start bit. If the vote at tick 9 of that bit is high, the receiver drops back to idle and delivers nothing.
- R4: The eight data bits follow the start bit, least significant bit first, and appear on `out_data`.
- R5: When `cfg_wake_en` is 1, one wakeup bit follows the data bits and is reported on `out_wake`. When it is 0, no such bit is expected and `out_wake` is 0.
- R6: When `cfg_par_en` is 1, a parity bit follows the wakeup bit (or the data bits). It covers only the data bits. With `cfg_par_odd` = 0 the expected parity bit is the XOR of the data bits, and with 1 it is the inverse of that XOR. A mismatch sets `out_par_err`, and the byte is still delivered. With parity disabled, `out_par_err` is 0.
- R7: A stop bit that votes low sets `out_frm_err`, and the byte is still delivered. The receiver then waits for the line to go high before it looks for a new start bit.
- R8: `out_valid` pulses for exactly one clock cycle per frame, at the stop-bit vote, with all result fields valid in that cycle. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_slow | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 32 |
| cfg_div | input | 8 | Rate divider value n; divides by n+1 |
| cfg_wake_en | input | 1 | Expect a wakeup bit after the data bits |
| cfg_par_en | input | 1 | Expect a parity bit |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| rx_in | input | 1 | Serial line; idles high |
| out_valid | output | 1 | One-cycle strobe marking a received frame |
| out_data | output | 8 | Received byte |
| out_wake | output | 1 | Received wakeup bit |
| out_par_err | output | 1 | Parity mismatch on this frame |
| out_frm_err | output | 1 | Stop bit voted low on this frame |

## Verification
Several properties are checked on every cycle. The tick is never asserted on two cycles in a row. The result strobe is always a single pulse. The wakeup and parity flags stay clear while their options are disabled. A rejected start vote always returns the receiver to idle, and a framing error always leaves it waiting for the line to go high. Other behaviour shows only in the bench scenarios, which compare delivered frames against a scoreboard: the actual bit rates for both prescaler settings, LSB-first assembly, parity sense, voting through a short spike inside a data bit, and the silent rejection of a short low pulse.

// File: rtl/mv_uart_rx.sv
module mv_uart_rx #(
  parameter int DW  = 8,
  parameter int NW  = 8,
  parameter int PSW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_slow,
  input  logic [NW-1:0] cfg_div,
  input  logic          cfg_wake_en,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          rx_in,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_wake,
  output logic          out_par_err,
  output logic          out_frm_err
);

  localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [PSW-1:0] PRE_FAST = PSW'(1);
  localparam logic [PSW-1:0] PRE_SLOW = PSW'(31);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_WAKE, S_PAR, S_STOP, S_WAITHI} st_t;

  st_t            state;
  logic           rx_m, rx_s;
  logic [PSW-1:0] pre_cnt;
  logic [NW-1:0]  div_cnt;
  logic [3:0]     tcnt;
  logic [BCW-1:0] bcnt;
  logic [DW-1:0]  shreg;
  logic           s0, s1, wake_r, perr_r;

  logic [PSW-1:0] pre_lim;
  logic           pre_tick, tick16, vote;
  logic           at_vote, at_end;

  assign pre_lim  = cfg_slow ? PRE_SLOW : PRE_FAST;
  assign pre_tick = (pre_cnt >= pre_lim);
  assign tick16   = pre_tick && (div_cnt >= cfg_div);
  assign vote     = (s0 & s1) | (s0 & rx_s) | (s1 & rx_s);
  assign at_vote  = tick16 && (tcnt == 4'd9);
  assign at_end   = tick16 && (tcnt == 4'd15);

  // R2: two-stage synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  // R1: prescaler and divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
      if (pre_tick) div_cnt <= (div_cnt >= cfg_div) ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tcnt        <= '0;
      bcnt        <= '0;
      shreg       <= '0;
      s0          <= 1'b1;
      s1          <= 1'b1;
      wake_r      <= 1'b0;
      perr_r      <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_wake    <= 1'b0;
      out_par_err <= 1'b0;
      out_frm_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick16 && state != S_IDLE && state != S_WAITHI) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt == 4'd7) s0 <= rx_s;
        if (tcnt == 4'd8) s1 <= rx_s;
      end
      case (state)
        S_IDLE: if (tick16 && !rx_s) begin
          state  <= S_START;
          tcnt   <= 4'd1;
          wake_r <= 1'b0;
          perr_r <= 1'b0;
        end
        S_START: begin
          if (at_vote && vote) state <= S_IDLE;
          else if (at_end) begin
            state <= S_DATA;
            bcnt  <= '0;
          end
        end
        S_DATA: begin
          if (at_vote) shreg <= {vote, shreg[DW-1:1]};
          if (at_end) begin
            if (bcnt == BCW'(DW-1))
              state <= cfg_wake_en ? S_WAKE : (cfg_par_en ? S_PAR : S_STOP);
            else
              bcnt <= bcnt + 1'b1;
          end
        end
        S_WAKE: begin
          if (at_vote) wake_r <= vote;
          if (at_end) state <= cfg_par_en ? S_PAR : S_STOP;
        end
        S_PAR: begin
          if (at_vote) perr_r <= vote ^ (^shreg) ^ cfg_par_odd;
          if (at_end) state <= S_STOP;
        end
        S_STOP: if (at_vote) begin
          out_valid   <= 1'b1;
          out_data    <= shreg;
          out_wake    <= cfg_wake_en & wake_r;
          out_par_err <= cfg_par_en & perr_r;
          out_frm_err <= ~vote;
          state       <= vote ? S_IDLE : S_WAITHI;
        end
        S_WAITHI: if (rx_s) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |=> !tick16);
  assert_glitch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && at_vote && vote) |=> (state == S_IDLE));
  assert_no_wake_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_wake_en) |-> !out_wake);
  assert_no_perr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_par_en) |-> !out_par_err);
  assert_ferr_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_frm_err) |-> (state == S_WAITHI));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: tb/mv_uart_rx_test.sv
module mv_uart_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_slow = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic cfg_wake_en = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic rx_in = 1'b1;
  logic out_valid, out_wake, out_par_err, out_frm_err;
  logic [7:0] out_data;

  typedef struct {
    logic [7:0] d;
    logic w, pe, fe;
    string req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, fails = 0;
  int bitclk = 32;
  string cur_req = "R8";

  always #5 clk = ~clk;

  mv_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_slow(cfg_slow), .cfg_div(cfg_div),
    .cfg_wake_en(cfg_wake_en), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rx_in(rx_in), .out_valid(out_valid), .out_data(out_data), .out_wake(out_wake),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err));

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, "unexpected frame", out_data, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(out_data == e.d, e.req, "data", out_data, e.d);
        check(out_wake == e.w, e.req, "wake", out_wake, e.w);
        check(out_par_err == e.pe, e.req, "par_err", out_par_err, e.pe);
        check(out_frm_err == e.fe, e.req, "frm_err", out_frm_err, e.fe);
      end
    end
  end

  task automatic config_rate(input bit slow, input int n);
    cfg_slow = slow;
    cfg_div = 8'(n);
    bitclk = 16 * (slow ? 32 : 2) * (n + 1);
  endtask

  task automatic drive_bit(input logic v, input bit spike);
    rx_in = v;
    if (spike) begin
      repeat (bitclk / 2 - 2) @(negedge clk);
      rx_in = ~v;
      repeat (4) @(negedge clk);
      rx_in = v;
      repeat (bitclk / 2 - 2) @(negedge clk);
    end else begin
      repeat (bitclk) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic wk, input bit flip_par,
                      input logic stop_v, input int spike_bit, input string req);
    item_t e;
    logic pbit;
    e.d = d;
    e.w = cfg_wake_en & wk;
    e.pe = cfg_par_en & flip_par;
    e.fe = ~stop_v;
    e.req = req;
    cur_req = req;
    exp_q.push_back(e);
    pbit = (^d) ^ cfg_par_odd ^ flip_par;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], i == spike_bit);
    if (cfg_wake_en) drive_bit(wk, 1'b0);
    if (cfg_par_en) drive_bit(pbit, 1'b0);
    drive_bit(stop_v, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8", "reset valid", out_valid, 0);
    check(out_data == 8'h00, "R8", "reset data", out_data, 0);
    check({out_wake, out_par_err, out_frm_err} == 3'b000, "R8", "reset flags",
          {out_wake, out_par_err, out_frm_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    config_rate(1'b0, 0);
    send(8'hA5, 1'b0, 1'b0, 1'b1, -1, "R4");
    send(8'h01, 1'b0, 1'b0, 1'b1, -1, "R4");
    send(8'h80, 1'b0, 1'b0, 1'b1, -1, "R4");

    config_rate(1'b0, 3);
    send(8'h3C, 1'b0, 1'b0, 1'b1, -1, "R1");
    send(8'h5A, 1'b0, 1'b0, 1'b1, 3, "R2");
    send(8'hC3, 1'b0, 1'b0, 1'b1, 6, "R2");

    cur_req = "R3";
    rx_in = 1'b0;
    repeat (bitclk / 4) @(negedge clk);
    rx_in = 1'b1;
    repeat (bitclk * 2) @(negedge clk);
    check(exp_q.size() == 0, "R3", "pending after glitch", exp_q.size(), 0);
    send(8'h77, 1'b0, 1'b0, 1'b1, -1, "R3");

    cfg_wake_en = 1'b1;
    send(8'h12, 1'b1, 1'b0, 1'b1, -1, "R5");
    send(8'h34, 1'b0, 1'b0, 1'b1, -1, "R5");
    cfg_par_en = 1'b1;
    send(8'h56, 1'b1, 1'b0, 1'b1, -1, "R6");
    send(8'h56, 1'b1, 1'b1, 1'b1, -1, "R6");
    cfg_wake_en = 1'b0;
    cfg_par_odd = 1'b1;
    send(8'h07, 1'b0, 1'b0, 1'b1, -1, "R6");
    send(8'h07, 1'b0, 1'b1, 1'b1, -1, "R6");
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    send(8'h9E, 1'b0, 1'b0, 1'b0, -1, "R7");
    send(8'h61, 1'b0, 1'b0, 1'b1, -1, "R7");

    config_rate(1'b1, 0);
    send(8'hD2, 1'b0, 1'b0, 1'b1, -1, "R1");

    repeat (bitclk) @(negedge clk);
    check(exp_q.size() == 0, "R8", "frames outstanding", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule